// File: doc/BRIEF.md
# Memory Self-Test Data Background Generator

This block supplies the write data for each burst of a memory self-test. It also supplies the expected read data for each burst, for a 72-lane data interface. An address sequencer runs a march over the array. It pulses `wr_burst` each time it consumes a write word and `rd_burst` each time it consumes an expected word. It pulses `march_done` when one full march pass has completed. The generator keeps separate write-side and read-side state, so the expected word for the n-th read burst of a run always equals the word written on the n-th write burst of that run. This holds however the sequencer interleaves reads and writes.

Three backgrounds are available:
- **Toggle mode** switches every lane together. Write bursts alternate between all zeros and all ones.
- **PRBS mode** streams a 31-stage pseudo-random sequence. The sequence is packed 72 bits per burst.
- **List mode** walks a host-loaded table of up to 94 fixed backgrounds. Typical entries are aggressor/victim arrangements around a chosen lane. The whole march is repeated once per table entry, and the block asks the sequencer for each rerun with a one-cycle restart pulse.

A sticky completion flag reports that the last run has ended.

Top module: `bgpat_gen`

## Requirements
- R1: After reset, `busy`, `all_done` and `restart_req` are 0, `list_idx` is 0 and `wr_data` is all zeros.
- R2: `start` is accepted only while `busy` is 0. When it is accepted, the block captures `mode_sel` and `list_len`, and `busy` is 1 from the next cycle. While `busy` is 1, `start`, `mode_sel` and `list_len` have no effect.
- R3: Toggle mode (`mode_sel` 0, and the spare code 3 behaves the same) numbers the write bursts of a run from 0. Burst n drives all zeros when n is even and all ones when n is odd. `wr_data` always shows the word for the next write burst and moves on in the cycle after each `wr_burst` seen while busy.
- R4: PRBS mode (`mode_sel` 1) uses a stream x in which x[n] = x[n-31] XOR x[n-28]. The 31 bits before x[0] are preloaded from the parameter `PRBS_SEED`: x[-1-k] is seed bit k. Write burst k of a run carries x[72k+j] on lane j. The stream restarts from the seed at the start of every run.
- R5: `exp_data` shows the expected word for the next read burst. For the n-th read burst of a run it equals the word of the n-th write burst of the same run in every mode. It moves on in the cycle after each `rd_burst` seen while busy.
- R6: List mode (`mode_sel` 2) drives both `wr_data` and `exp_data` with table entry `list_idx`. `list_idx` is 0 for the first run.
- R7: In list mode, a `march_done` while entries remain does four things on the next cycle: it increments `list_idx`, raises `restart_req` for exactly one cycle, keeps `busy` at 1, and restarts both burst counts at 0.
- R8: A `march_done` that ends the session clears `busy` and sets `all_done` on the next cycle. In list mode this is the `march_done` on the last entry; in the other modes it is the first one. `all_done` then stays 1 until the next accepted `start`, which clears it.
- R9: A captured `list_len` of 0 is treated as 1 and a value above 94 is treated as 94. List mode therefore performs between 1 and 94 runs.
- R10: A host write (`host_we`) stores `host_wdata` at `host_addr` only while `busy` is 0 and `host_addr` is below 94. Any other host write leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (accepted when idle) |
| mode_sel | input | 2 | Background mode: 0 toggle, 1 PRBS, 2 list, 3 toggle |
| list_len | input | 7 | Number of table entries to run in list mode |
| host_we | input | 1 | Table write strobe |
| host_addr | input | 7 | Table write index |
| host_wdata | input | 72 | Table write word |
| wr_burst | input | 1 | Sequencer consumed the current write word |
| rd_burst | input | 1 | Sequencer consumed the current expected word |
| march_done | input | 1 | One full march pass finished |
| wr_data | output | 72 | Write word for the next write burst |
| exp_data | output | 72 | Expected word for the next read burst |
| busy | output | 1 | Session in progress |
| restart_req | output | 1 | One-cycle request to rerun the march with the next entry |
| list_idx | output | 7 | Table entry in use |
| all_done | output | 1 | Session complete (sticky until next start) |

## Verification
The bound checker covers several rules on every clock:
- the restart pulse is one cycle wide, follows a `march_done`, and steps the index by one;
- the index never leaves the table;
- `all_done` can only rise as `busy` falls;
- a toggle-mode write word is always uniform;
- in list mode the write and expected words always agree.

The exact stream contents cannot be written as a short property, and neither can the parity order, the way expected words track arbitrarily interleaved bursts, the length clamp, or the rejection of host writes during a run. For these, the bench runs a behavioural model beside the design with directed scenarios: mixed burst orders, back-to-back sessions, busy-time writes, and list lengths of 0 and 120.

// File: rtl/bgpat_pkg.sv
package bgpat_pkg;

  // Background mode codes as presented on mode_sel.
  typedef enum logic [1:0] {
    BG_TOGGLE   = 2'd0,
    BG_PRBS     = 2'd1,
    BG_LIST     = 2'd2,
    BG_TOGGLE_B = 2'd3
  } bg_mode_e;

  // Side selector for the write/read generator pair.
  localparam int unsigned BG_SIDES  = 2;
  localparam int unsigned BG_SIDE_WR = 0;
  localparam int unsigned BG_SIDE_RD = 1;

endpackage

// File: rtl/bgpat_store.sv
// Table of fixed backgrounds: one host write port, one asynchronous read port.
module bgpat_store #(
  parameter int unsigned LANES = 72,
  parameter int unsigned DEPTH = 94,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LANES-1:0] rd_word
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [LANES-1:0] table_q [DEPTH];
  logic             wr_in_range;
  logic [IDX_W-1:0] rd_safe;

  assign wr_in_range = (wr_idx <= LAST_IDX);
  assign rd_safe     = (rd_idx <= LAST_IDX) ? rd_idx : LAST_IDX;

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      table_q[wr_idx] <= wr_word;
    end
  end

  assign rd_word = table_q[rd_safe];

endmodule

// File: rtl/bgpat_stream.sv
// One side (write or read) of the background generator: burst parity plus
// a 72-bits-per-burst pseudo-random stream. Both sides are identical so
// the read side replays exactly what the write side produced.
module bgpat_stream #(
  parameter int unsigned         LANES    = 72,
  parameter int unsigned         LFSR_W   = 31,
  parameter int unsigned         LFSR_TAP = 28,
  parameter logic [LFSR_W-1:0]   SEED     = 31'h2A5C_3F19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             adv,
  output logic             par,
  output logic [LANES-1:0] word
);

  logic [LFSR_W-1:0] lfsr_q;
  logic              par_q;

  // Produce the LANES stream bits that follow state s; lane 0 gets the first.
  function automatic logic [LANES-1:0] stream_word(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic [LANES-1:0]  w;
    logic              b;
    t = s;
    w = '0;
    for (int j = 0; j < LANES; j++) begin
      b    = t[LFSR_W-1] ^ t[LFSR_TAP-1];
      w[j] = b;
      t    = {t[LFSR_W-2:0], b};
    end
    return w;
  endfunction

  // State after LANES stream bits have been produced.
  function automatic logic [LFSR_W-1:0] stream_next(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic              b;
    t = s;
    for (int j = 0; j < LANES; j++) begin
      b = t[LFSR_W-1] ^ t[LFSR_TAP-1];
      t = {t[LFSR_W-2:0], b};
    end
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      par_q  <= 1'b0;
    end else if (reload) begin
      lfsr_q <= SEED;
      par_q  <= 1'b0;
    end else if (adv) begin
      lfsr_q <= stream_next(lfsr_q);
      par_q  <= ~par_q;
    end
  end

  assign par  = par_q;
  assign word = stream_word(lfsr_q);

endmodule

// File: rtl/bgpat_ctrl.sv
// Session control: start capture, per-entry run sequencing, completion flag.
module bgpat_ctrl
  import bgpat_pkg::*;
#(
  parameter int unsigned DEPTH = 94,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [IDX_W-1:0] list_len,
  input  logic             march_done,
  output bg_mode_e         run_mode,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             reload,
  output logic             restart_req,
  output logic             all_done,
  output logic             start_go,
  output logic             step_next,
  output logic             finish
);

  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] ONE_V   = IDX_W'(1);

  bg_mode_e         mode_q;
  logic             busy_q;
  logic             done_q;
  logic             req_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] len_q;
  logic             run_end;
  logic             more_left;

  function automatic logic [IDX_W-1:0] clamp_len(input logic [IDX_W-1:0] l);
    if (l == '0)         return ONE_V;
    else if (l > DEPTH_V) return DEPTH_V;
    else                 return l;
  endfunction

  assign start_go  = !busy_q && start;
  assign run_end   = busy_q && march_done;
  assign more_left = (idx_q + ONE_V) < len_q;
  assign step_next = run_end && (mode_q == BG_LIST) && more_left;
  assign finish    = run_end && !step_next;
  assign reload    = start_go || step_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= BG_TOGGLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
      idx_q  <= '0;
      len_q  <= ONE_V;
    end else begin
      req_q <= step_next;
      if (start_go) begin
        mode_q <= bg_mode_e'(mode_sel);
        len_q  <= clamp_len(list_len);
        idx_q  <= '0;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (step_next) begin
        idx_q <= idx_q + ONE_V;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign run_mode    = mode_q;
  assign busy        = busy_q;
  assign idx         = idx_q;
  assign restart_req = req_q;
  assign all_done    = done_q;

endmodule

// File: rtl/bgpat_gen.sv
// Top: data background generator for memory self-test.
module bgpat_gen
  import bgpat_pkg::*;
#(
  parameter int unsigned       LANES     = 72,
  parameter int unsigned       DEPTH     = 94,
  parameter int unsigned       IDX_W     = 7,
  parameter int unsigned       LFSR_W    = 31,
  parameter int unsigned       LFSR_TAP  = 28,
  parameter logic [LFSR_W-1:0] PRBS_SEED = 31'h2A5C_3F19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [IDX_W-1:0] list_len,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_addr,
  input  logic [LANES-1:0] host_wdata,
  input  logic             wr_burst,
  input  logic             rd_burst,
  input  logic             march_done,
  output logic [LANES-1:0] wr_data,
  output logic [LANES-1:0] exp_data,
  output logic             busy,
  output logic             restart_req,
  output logic [IDX_W-1:0] list_idx,
  output logic             all_done
);

  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  bg_mode_e         run_mode;
  logic             reload;
  logic             start_go;
  logic             step_next;
  logic             finish;
  logic             table_we;
  logic [LANES-1:0] table_word;

  logic [BG_SIDES-1:0] side_burst;
  logic [BG_SIDES-1:0] side_adv;
  logic [BG_SIDES-1:0] side_par;
  logic [LANES-1:0]    side_prbs [BG_SIDES];
  logic [LANES-1:0]    side_word [BG_SIDES];

  // Select the background word for one side from its parity and stream state.
  function automatic logic [LANES-1:0] pick_word(
    input bg_mode_e         m,
    input logic             p,
    input logic [LANES-1:0] prbs_w,
    input logic [LANES-1:0] list_w
  );
    case (m)
      BG_PRBS: return prbs_w;
      BG_LIST: return list_w;
      default: return {LANES{p}};
    endcase
  endfunction

  bgpat_ctrl #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mode_sel    (mode_sel),
    .list_len    (list_len),
    .march_done  (march_done),
    .run_mode    (run_mode),
    .busy        (busy),
    .idx         (list_idx),
    .reload      (reload),
    .restart_req (restart_req),
    .all_done    (all_done),
    .start_go    (start_go),
    .step_next   (step_next),
    .finish      (finish)
  );

  assign table_we = host_we && !busy && (host_addr < DEPTH_V);

  bgpat_store #(
    .LANES (LANES),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (table_we),
    .wr_idx  (host_addr),
    .wr_word (host_wdata),
    .rd_idx  (list_idx),
    .rd_word (table_word)
  );

  assign side_burst[BG_SIDE_WR] = wr_burst;
  assign side_burst[BG_SIDE_RD] = rd_burst;

  for (genvar s = 0; s < BG_SIDES; s++) begin : g_side
    assign side_adv[s] = busy && side_burst[s] && !reload;

    bgpat_stream #(
      .LANES    (LANES),
      .LFSR_W   (LFSR_W),
      .LFSR_TAP (LFSR_TAP),
      .SEED     (PRBS_SEED)
    ) u_stream (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload),
      .adv    (side_adv[s]),
      .par    (side_par[s]),
      .word   (side_prbs[s])
    );

    assign side_word[s] = pick_word(run_mode, side_par[s], side_prbs[s], table_word);
  end

  assign wr_data  = side_word[BG_SIDE_WR];
  assign exp_data = side_word[BG_SIDE_RD];

endmodule

// File: rtl/bgpat_gen_chk.sv
// Cycle-level properties of the background generator.
module bgpat_gen_chk
  import bgpat_pkg::*;
#(
  parameter int unsigned LANES = 72,
  parameter int unsigned DEPTH = 94,
  parameter int unsigned IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             march_done,
  input logic [LANES-1:0] wr_data,
  input logic [LANES-1:0] exp_data,
  input logic             busy,
  input logic             restart_req,
  input logic [IDX_W-1:0] list_idx,
  input logic             all_done,
  input bg_mode_e         run_mode
);

  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req); // R7

  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> ($past(march_done) && busy && run_mode == BG_LIST)); // R7

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (list_idx == $past(list_idx) + IDX_W'(1))); // R7

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    list_idx < DEPTH_V); // R9

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && list_idx == '0 && !all_done)); // R2

  AST_IDLE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(list_idx)); // R2

  AST_DONE_WITH_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_done) |-> (!busy && $past(busy) && $past(march_done))); // R8

  AST_TOGGLE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (run_mode == BG_TOGGLE || run_mode == BG_TOGGLE_B)) |->
      (wr_data == '0 || wr_data == '1)); // R3

  AST_LIST_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_mode == BG_LIST) |-> (wr_data == exp_data)); // R6

endmodule

bind bgpat_gen bgpat_gen_chk #(
  .LANES (LANES),
  .DEPTH (DEPTH),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .march_done  (march_done),
  .wr_data     (wr_data),
  .exp_data    (exp_data),
  .busy        (busy),
  .restart_req (restart_req),
  .list_idx    (list_idx),
  .all_done    (all_done),
  .run_mode    (run_mode)
);

// File: tb/bgpat_gen_test.sv
`timescale 1ns/1ps
module bgpat_gen_test;

  localparam int LANES = 72;
  localparam int DEPTH = 94;
  localparam int IDX_W = 7;
  localparam logic [30:0] SEED = 31'h2A5C_3F19;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       mode_sel = 2'd0;
  logic [IDX_W-1:0] list_len = '0;
  logic             host_we = 1'b0;
  logic [IDX_W-1:0] host_addr = '0;
  logic [LANES-1:0] host_wdata = '0;
  logic             wr_burst = 1'b0;
  logic             rd_burst = 1'b0;
  logic             march_done = 1'b0;
  logic [LANES-1:0] wr_data;
  logic [LANES-1:0] exp_data;
  logic             busy;
  logic             restart_req;
  logic [IDX_W-1:0] list_idx;
  logic             all_done;

  always #2 clk = ~clk;

  bgpat_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .list_len(list_len), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .wr_burst(wr_burst), .rd_burst(rd_burst),
    .march_done(march_done), .wr_data(wr_data), .exp_data(exp_data),
    .busy(busy), .restart_req(restart_req), .list_idx(list_idx),
    .all_done(all_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_restarts = 0;
  bit model_live = 0;

  // Behavioural reference model
  bit               m_busy, m_done, m_req;
  int               m_mode, m_len, m_idx, m_wn, m_rn;
  logic [LANES-1:0] m_tab [DEPTH];
  bit               hist[$];

  function automatic logic [LANES-1:0] ref_prbs(int k);
    logic [LANES-1:0] w;
    while (hist.size() < 31 + LANES * (k + 1))
      hist.push_back(hist[hist.size()-31] ^ hist[hist.size()-28]);
    for (int j = 0; j < LANES; j++) w[j] = hist[31 + LANES * k + j];
    return w;
  endfunction

  function automatic logic [LANES-1:0] ref_word(int n);
    if (m_mode == 1) return ref_prbs(n);
    if (m_mode == 2) return m_tab[m_idx];
    return (n % 2 == 1) ? {LANES{1'b1}} : {LANES{1'b0}};
  endfunction

  function automatic logic [LANES-1:0] pat_of(int i);
    logic [LANES-1:0] w;
    w = '0;
    w[i % LANES] = 1'b1;
    w = w ^ {LANES{i[0]}};
    w[71:64] = 8'(i);
    return w;
  endfunction

  task automatic check(string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    for (int k = 30; k >= 0; k--) hist.push_back(SEED[k]);
    for (int i = 0; i < DEPTH; i++) m_tab[i] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_req = 0; m_mode = 0; m_len = 1;
      m_idx = 0; m_wn = 0; m_rn = 0;
    end else begin
      bit go, endr, nxt, was_busy;
      was_busy = m_busy;
      go   = !m_busy && start;
      endr = m_busy && march_done;
      nxt  = endr && m_mode == 2 && (m_idx + 1 < m_len);
      m_req = nxt;
      if (host_we && !m_busy && host_addr < DEPTH) m_tab[host_addr] = host_wdata;
      if (go) begin
        m_busy = 1; m_done = 0; m_mode = mode_sel; m_idx = 0; m_wn = 0; m_rn = 0;
        m_len = (list_len == 0) ? 1 : (list_len > DEPTH ? DEPTH : int'(list_len));
      end else if (nxt) begin
        m_idx++; m_wn = 0; m_rn = 0;
      end else begin
        if (was_busy && wr_burst) m_wn++;
        if (was_busy && rd_burst) m_rn++;
        if (endr) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_live) begin
      check("R2 busy", LANES'(busy), LANES'(m_busy));
      check("R8 all_done", LANES'(all_done), LANES'(m_done));
      check("R7 restart_req", LANES'(restart_req), LANES'(m_req));
      check("R7 list_idx", LANES'(list_idx), LANES'(m_idx));
      if (restart_req) n_restarts++;
      if (m_busy) begin
        check(m_mode == 1 ? "R4 wr_data" : (m_mode == 2 ? "R6 wr_data" : "R3 wr_data"),
              wr_data, ref_word(m_wn));
        check("R5 exp_data", exp_data, ref_word(m_rn));
      end
    end
  end

  task automatic step(bit st, bit w, bit r, bit md);
    start = st; wr_burst = w; rd_burst = r; march_done = md;
    @(negedge clk);
    start = 0; wr_burst = 0; rd_burst = 0; march_done = 0;
  endtask

  task automatic host_write(int a, logic [LANES-1:0] d);
    host_we = 1; host_addr = IDX_W'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic begin_run(int mode, int len);
    mode_sel = 2'(mode); list_len = IDX_W'(len);
    step(1, 0, 0, 0);
  endtask

  // A march pass: n writes, then n reads with a few mixed cycles.
  task automatic march(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", LANES'(busy), '0);
    check("R1 all_done", LANES'(all_done), '0);
    check("R1 restart_req", LANES'(restart_req), '0);
    check("R1 list_idx", LANES'(list_idx), '0);
    check("R1 wr_data", wr_data, '0);
    model_live = 1;

    // R10: load the table while idle, plus an out-of-range write
    for (int i = 0; i < DEPTH; i++) host_write(i, pat_of(i));
    host_write(100, {LANES{1'b1}});

    // R3: toggle mode, then spare code 3
    begin_run(0, 0);
    step(1, 0, 0, 0);            // start while busy: ignored (R2)
    march(5);
    step(0, 1, 1, 0); step(0, 1, 0, 0); step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    begin_run(3, 0);
    march(3);
    step(0, 0, 0, 1);

    // R4/R5: PRBS mode, two sessions (reseed), interleaved bursts
    for (int s = 0; s < 2; s++) begin
      begin_run(1, 0);
      march(6);
      step(0, 1, 0, 0); step(0, 1, 1, 0); step(0, 0, 1, 0);
      step(0, 0, 0, 1);
    end

    // R6/R7/R10: list of 4, host write during the run is refused
    begin_run(2, 4);
    host_write(1, {LANES{1'b0}});
    march(2); step(0, 0, 0, 1);
    @(negedge clk);
    check("R10 entry kept", wr_data, pat_of(1));
    march(2); step(0, 0, 0, 1);
    march(1); step(0, 1, 0, 1);
    march(1); step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R8 all_done after list", LANES'(all_done), LANES'(1));
    check("R7 restarts for 4 entries", LANES'(n_restarts), LANES'(3));

    // R9: length 0 runs once
    n_restarts = 0;
    begin_run(2, 0);
    march(1); step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check("R9 len 0 runs once", LANES'(n_restarts), '0);
    check("R9 len 0 done", LANES'(all_done), LANES'(1));

    // R9: length 120 clamps to 94
    n_restarts = 0;
    begin_run(2, 120);
    for (int e = 0; e < 120 && busy; e++) begin
      step(0, 1, 1, 0);
      step(0, 0, 0, 1);
    end
    step(0, 0, 0, 0);
    check("R9 len clamp restarts", LANES'(n_restarts), LANES'(DEPTH - 1));
    check("R9 len clamp done", LANES'(all_done), LANES'(1));

    // R8: done stays until the next start, which clears it
    repeat (3) step(0, 1, 1, 0);
    check("R8 done sticky", LANES'(all_done), LANES'(1));
    begin_run(0, 0);
    check("R8 start clears done", LANES'(all_done), '0);
    step(0, 0, 0, 1);
    repeat (2) step(0, 0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule